// File: doc/BRIEF.md
# Subtractive GCD Engine

This block finds the greatest common divisor of two nonzero 16-bit unsigned operands by repeated subtraction. A one-cycle start strobe in the idle state captures both operands into two working registers. On every following clock the block compares the two registers. While they differ, it subtracts the smaller from the larger and writes the difference back into the larger one's register, all in that same clock. When the registers match, the common value is the answer. It appears on the result port, and a one-cycle completion pulse announces it.

The controller has only three states: idle, compare and done. The operand capture and the subtract-and-writeback steps are issued on transitions, as conditional outputs, and are not given states of their own. A run therefore costs one clock per subtraction plus two clocks of overhead. Operands of zero are outside the contract.

Top module: `gcd_engine`

## Requirements
- R1: While reset is low and right after reset, `done` is 0, `result` is 0 and the engine is idle, so a start in the first clock after reset is accepted.
- R2: A clock edge at which `start` is 1 in the idle state loads register A from `opnd_x` and register B from `opnd_y`.
- R3: In the compare state, when A > B, A becomes A - B at the next edge. When A < B, B becomes B - A at the next edge. Each such step takes exactly one clock.
- R4: When A equals B in the compare state, `done` goes high at the next edge and `result` then equals the GCD of the loaded operands (for example 12 and 9 give 3).
- R5: `done` is high for exactly one cycle, after which the engine is idle again and accepts a new start.
- R6: If the operands need S subtraction steps, `done` is first high after the (S+1)-th clock edge that follows the edge that accepted `start`.
- R7: While a computation runs, `start` pulses and changes on `opnd_x`/`opnd_y` have no effect on the result or the latency.
- R8: `result` is always register A. It changes only on an operand load or an A-subtraction, so after completion it holds the answer until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a computation; sampled only in idle |
| opnd_x | input | 16 | First operand, nonzero |
| opnd_y | input | 16 | Second operand, nonzero |
| result | output | 16 | Contents of register A; the GCD once `done` pulses |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach from the ports is a start pulse, with fresh operands, that arrives while a computation is already running. The bench drives a known pair and, a cycle later, raises `start` again with different operand values. It then checks that both the answer and the edge count match the first pair alone. A reset in the middle of a long run is the other hard case. The bench starts a thousand-step run, pulls reset partway through, confirms the cleared outputs, and then completes a fresh computation.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

  localparam int unsigned GCD_W_DEF = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMP  = 2'd1,
    ST_FIN  = 2'd2
  } gcd_state_t;

  // one bit of a borrow-ripple subtractor: returns {borrow_out, diff}
  function automatic logic [1:0] sub_bit(input logic a, input logic b, input logic bin);
    logic d;
    logic bo;
    d  = a ^ b ^ bin;
    bo = (~a & b) | (~(a ^ b) & bin);
    return {bo, d};
  endfunction

endpackage

// File: rtl/gcd_sub.sv
module gcd_sub #(
  parameter int unsigned W = gcd_pkg::GCD_W_DEF
) (
  input  logic [W-1:0] minu,
  input  logic [W-1:0] subt,
  output logic [W-1:0] diff
);
  logic [W-1:0] brw;

  assign brw[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] r;
    assign r       = gcd_pkg::sub_bit(minu[i], subt[i], brw[i]);
    assign diff[i] = r[0];
    if (i < W - 1) begin : g_chain
      assign brw[i+1] = r[1];
    end
  end
endmodule

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
  import gcd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic eq,
  input  logic gt,
  output logic ld_ops,
  output logic sub_a,
  output logic sub_b,
  output logic hit_eq,
  output logic done
);
  gcd_state_t st_q, st_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    st_d   = st_q;
    ld_ops = 1'b0;
    sub_a  = 1'b0;
    sub_b  = 1'b0;
    hit_eq = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          ld_ops = 1'b1;
          st_d   = ST_CMP;
        end
      end
      ST_CMP: begin
        if (eq) begin
          hit_eq = 1'b1;
          st_d   = ST_FIN;
        end else if (gt) begin
          sub_a = 1'b1;
        end else begin
          sub_b = 1'b1;
        end
      end
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign done = (st_q == ST_FIN);
endmodule

// File: rtl/gcd_dpath.sv
module gcd_dpath #(
  parameter int unsigned W = gcd_pkg::GCD_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_ops,
  input  logic         sub_a,
  input  logic         sub_b,
  input  logic [W-1:0] opnd_x,
  input  logic [W-1:0] opnd_y,
  output logic [W-1:0] a_q,
  output logic [W-1:0] b_q,
  output logic         eq,
  output logic         gt
);
  logic [W-1:0] minu, subt, diff;

  // larger operand is the minuend; select follows the comparison outcome
  assign minu = gt ? a_q : b_q;
  assign subt = gt ? b_q : a_q;

  gcd_sub #(.W(W)) u_sub (
    .minu (minu),
    .subt (subt),
    .diff (diff)
  );

  assign eq = (a_q == b_q);
  assign gt = (a_q > b_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (ld_ops)     a_q <= opnd_x;
      else if (sub_a) a_q <= diff;
      if (ld_ops)     b_q <= opnd_y;
      else if (sub_b) b_q <= diff;
    end
  end
endmodule

// File: rtl/gcd_engine.sv
module gcd_engine #(
  parameter int unsigned W = gcd_pkg::GCD_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] opnd_x,
  input  logic [W-1:0] opnd_y,
  output logic [W-1:0] result,
  output logic         done
);
  // named internal events, visible to the bound checker
  logic         ld_ops, sub_a, sub_b, hit_eq;
  logic         eq, gt;
  logic [W-1:0] a_val, b_val;

  gcd_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .eq     (eq),
    .gt     (gt),
    .ld_ops (ld_ops),
    .sub_a  (sub_a),
    .sub_b  (sub_b),
    .hit_eq (hit_eq),
    .done   (done)
  );

  gcd_dpath #(.W(W)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_ops (ld_ops),
    .sub_a  (sub_a),
    .sub_b  (sub_b),
    .opnd_x (opnd_x),
    .opnd_y (opnd_y),
    .a_q    (a_val),
    .b_q    (b_val),
    .eq     (eq),
    .gt     (gt)
  );

  assign result = a_val;
endmodule

// File: rtl/gcd_engine_chk.sv
module gcd_engine_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ld_ops,
  input logic         sub_a,
  input logic         sub_b,
  input logic         hit_eq,
  input logic         done,
  input logic [W-1:0] opnd_x,
  input logic [W-1:0] opnd_y,
  input logic [W-1:0] result,
  input logic [W-1:0] b_val
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |-> (done == 1'b0 && result == '0));

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ops |=> (result == $past(opnd_x) && b_val == $past(opnd_y)));

  // R3
  sub_a_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_a |=> (result == $past(result) - $past(b_val) && b_val == $past(b_val)));

  // R3
  sub_b_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_b |=> (b_val == $past(b_val) - $past(result) && result == $past(result)));

  // R4
  eq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_eq |=> done);

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_ops && !sub_a) |=> $stable(result));

  // R7
  one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_ops, sub_a, sub_b, hit_eq, done}));
endmodule

bind gcd_engine gcd_engine_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ld_ops (ld_ops),
  .sub_a  (sub_a),
  .sub_b  (sub_b),
  .hit_eq (hit_eq),
  .done   (done),
  .opnd_x (opnd_x),
  .opnd_y (opnd_y),
  .result (result),
  .b_val  (b_val)
);

// File: tb/gcd_engine_test.sv
module gcd_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] opnd_x = '0;
  logic [15:0] opnd_y = '0;
  logic [15:0] result;
  logic        done;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  gcd_engine uut (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .opnd_x (opnd_x),
    .opnd_y (opnd_y),
    .result (result),
    .done   (done)
  );

  localparam int NV = 12;
  // {x, y, expected gcd}
  localparam logic [15:0] VEC [NV][3] = '{
    '{16'd12,    16'd9,     16'd3},
    '{16'd9,     16'd12,    16'd3},
    '{16'd7,     16'd7,     16'd7},
    '{16'd1,     16'd1,     16'd1},
    '{16'd17,    16'd5,     16'd1},
    '{16'd48,    16'd18,    16'd6},
    '{16'd13,    16'd26,    16'd13},
    '{16'd40000, 16'd30000, 16'd10000},
    '{16'd2,     16'd65534, 16'd2},
    '{16'd65535, 16'd65535, 16'd65535},
    '{16'd1000,  16'd1,     16'd1},
    '{16'd65535, 16'd1,     16'd1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // number of subtraction steps, counted via quotients of Euclid's division
  function automatic int steps_of(input int x, input int y);
    int a = x;
    int b = y;
    int n = 0;
    while (a != 0 && b != 0) begin
      if (a >= b) begin n += a / b; a = a % b; end
      else        begin n += b / a; b = b % a; end
    end
    return n - 1;
  endfunction

  // run one computation; poke=1 disturbs start and operands mid-run
  task automatic run(input logic [15:0] x, input logic [15:0] y, input bit poke,
                     output logic [15:0] res, output int lat);
    @(negedge clk);
    opnd_x = x; opnd_y = y; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 70000) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (poke && lat == 1) begin start = 1'b1; opnd_x = 16'd7; opnd_y = 16'd5; end
      if (poke && lat == 2) begin start = 1'b0; opnd_x = 16'd3; end
    end
    res = result;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] res;
    int lat;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(done == 1'b0, "R1 done in reset", done, 0);
    chk(result == 16'd0, "R1 result in reset", result, 0);
    rst_n = 1'b1;

    // R1 start accepted in first cycle after reset
    run(16'd12, 16'd9, 1'b0, res, lat);
    chk(res == 16'd3, "R1 R4 first run result", res, 3);

    for (int i = 0; i < NV; i++) begin
      run(VEC[i][0], VEC[i][1], 1'b0, res, lat);
      chk(res == VEC[i][2], "R4 gcd result", res, VEC[i][2]);               // R4
      chk(lat == steps_of(VEC[i][0], VEC[i][1]) + 1, "R3 R6 latency", lat,
          steps_of(VEC[i][0], VEC[i][1]) + 1);                               // R6
      @(negedge clk);
      chk(done == 1'b0, "R5 done single cycle", done, 0);                    // R5
      repeat (3) @(negedge clk);
      chk(result == VEC[i][2], "R8 result held", result, VEC[i][2]);         // R8
    end

    // R7 start and operand changes during a run are ignored
    run(16'd48, 16'd18, 1'b1, res, lat);
    chk(res == 16'd6, "R7 result unaffected", res, 6);
    chk(lat == 5, "R7 latency unaffected", lat, 5);
    opnd_x = 16'd0; opnd_y = 16'd0;

    // R2 loads exactly the given operands: 9,12 -> one B step then A holds 9 first
    @(negedge clk);
    opnd_x = 16'd9; opnd_y = 16'd12; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(result == 16'd9, "R2 operand A loaded", result, 9);
    @(negedge clk);
    chk(result == 16'd9, "R3 A kept while B reduced", result, 9);            // 12-9 -> B=3
    @(negedge clk);
    chk(result == 16'd6, "R3 A reduced by B", result, 6);
    repeat (4) @(negedge clk);

    // R1 reset in mid-run clears outputs, then a fresh run works
    @(negedge clk);
    opnd_x = 16'd1000; opnd_y = 16'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R1 done after mid-run reset", done, 0);
    chk(result == 16'd0, "R1 result after mid-run reset", result, 0);
    @(negedge clk);
    rst_n = 1'b1;
    run(16'd12, 16'd9, 1'b0, res, lat);
    chk(res == 16'd3, "R1 result after reset", res, 3);
    chk(lat == 4, "R6 latency after reset", lat, 4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule